// File: doc/BRIEF.md
# Multi-View Tagged FIFO Cell

This block is one storage cell for passing words between threads. It holds a small circular buffer and a tag word made of two status flags (empty and full), a spare software flag, an entry count and a fixed depth code. The cell does not decode addresses. Each request names a view, and the view decides what the access means. The raw view reaches the buffer directly. The tag view reads or rewrites the status word. The two queue views push and pop entries: one waits when the cell cannot serve the request, and the other always completes.

A waiting request does not change the cell. It gets a stall response, and the cell records the requester's identifier in a parked-requester mask. The next queue-view request that is served sends out the whole mask as a one-cycle wake vector and clears the mask. Halting and resuming threads are left to an outside scheduler, which acts on the stall response and the wake vector. Software may set or clear the empty and full flags through the tag view, so the flags can disagree with the entry count. Every decision in the queue views follows the flags, except the push and pop limits, which follow the count.

Top module: `itc_fifo_cell`

## Requirements
- R1: After reset the count, both pointers and the parked mask are zero, the empty flag is 1 and the full and spare flags are 0. With the default depth of 8, a tag-view read returns 0x30020001, and the outputs rsp_valid, rsp_rdata and wake_vec are zero.
- R2: Every request with req_valid high gives rsp_valid high for exactly one cycle, one cycle later, with rsp_stall and rsp_rdata. A write response carries rdata 0. Without a request, rsp_valid stays low.
- R3: View codes are 0 raw, 1 tag, 2 queue-waiting and 3 queue-polling. A tag read returns the depth code log2(DEPTH) in bits 31:28, the count in bits 27:18, the constant queue-mode flag 1 in bit 17, the spare flag in bit 16, full in bit 1 and empty in bit 0. All other bits read 0.
- R4: A tag write loads the spare flag from wdata bit 16, empty from bit 0 and full from bit 1, and changes nothing else. If the loaded empty flag is 1, the count also becomes 0.
- R5: A served queue read clears full. If entries are present, it returns the oldest entry, removes it and advances the read pointer modulo DEPTH; otherwise it returns 0. If the count is then 0, empty is set.
- R6: A served queue write clears empty. If the count is below DEPTH, it appends the data; otherwise the data is dropped. If the count then equals DEPTH, full is set.
- R7: A queue-waiting read while empty is 1 stalls. rsp_stall is 1 and rdata is 0. The cell sets the requester's bit in the parked mask and clears full, and nothing else changes.
- R8: A queue-waiting write while full is 1 stalls. rsp_stall is 1, the cell sets the requester's bit in the parked mask and clears empty, and the data is not stored.
- R9: Every served queue-view request drives the parked mask onto wake_vec in its response cycle and clears the mask. wake_vec is 0 in every other cycle.
- R10: A raw read returns the entry at the read pointer and does not remove it. A raw write replaces the newest entry when the count is nonzero and is ignored when the count is zero.
- R11: A request with view codes 4 to 15 reads all ones and, as a write, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_view | input | 4 | View code |
| req_id | input | ID_W | Requester identifier |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_stall | output | 1 | Request must wait and was parked |
| rsp_rdata | output | DATA_W | Read data |
| wake_vec | output | 2**ID_W | One-cycle wake pulse, one bit per requester |

## Verification
Every result of a request is registered once: the response fields, the wake vector and the tag and buffer state all appear one clock edge after the request is presented. The bench drives each request on a falling edge and compares rsp_valid, rsp_stall, rsp_rdata and wake_vec on the next falling edge against a behavioural model. The model is stepped once per request. On cycles without a request, the bench checks that the response and wake outputs stay quiet. Queue state such as count and flags is checked through later tag-view reads, one cycle behind the access that changed it.

// File: rtl/itc_cell_pkg.sv
package itc_cell_pkg;

   localparam logic [3:0] VIEW_RAW     = 4'd0;
   localparam logic [3:0] VIEW_TAG     = 4'd1;
   localparam logic [3:0] VIEW_Q_WAIT  = 4'd2;
   localparam logic [3:0] VIEW_Q_POLL  = 4'd3;

   localparam int TAG_DEPTH_LSB = 28;
   localparam int TAG_DEPTH_W   = 4;
   localparam int TAG_COUNT_LSB = 18;
   localparam int TAG_COUNT_W   = 10;
   localparam int TAG_QMODE_BIT = 17;
   localparam int TAG_SPARE_BIT = 16;
   localparam int TAG_FULL_BIT  = 1;
   localparam int TAG_EMPTY_BIT = 0;

   typedef enum logic [2:0] {
      OP_IDLE,
      OP_CTL_WR,
      OP_POP,
      OP_PUSH,
      OP_HOLD_RD,
      OP_HOLD_WR
   } tag_op_e;

endpackage

// File: rtl/itc_cell_store.sv
module itc_cell_store #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 64,
   parameter int PTR_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_slot,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  rd_slot,
   output logic [DATA_W-1:0] rd_data
);

   logic [DATA_W-1:0] slot_q [DEPTH];

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[s] <= '0;
         end else if (wr_en && (wr_slot == PTR_W'(s))) begin
            slot_q[s] <= wr_data;
         end
      end
   end

   assign rd_data = slot_q[rd_slot];

endmodule

// File: rtl/itc_cell_tag.sv
module itc_cell_tag
   import itc_cell_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int PTR_W = 3,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tag_op_e          op,
   input  logic             ctl_spare,
   input  logic             ctl_empty,
   input  logic             ctl_full,
   output logic             flag_spare,
   output logic             flag_empty,
   output logic             flag_full,
   output logic [CNT_W-1:0] count,
   output logic [PTR_W-1:0] head,
   output logic             push_ok,
   output logic             pop_ok
);

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   logic             spare_n, empty_n, full_n;
   logic [CNT_W-1:0] cnt_n;
   logic [PTR_W-1:0] head_n;

   assign push_ok = (op == OP_PUSH) && (count < CNT_FULL);
   assign pop_ok  = (op == OP_POP) && (count != '0);

   always_comb begin
      spare_n = flag_spare;
      empty_n = flag_empty;
      full_n  = flag_full;
      cnt_n   = count;
      head_n  = head;
      case (op)
         OP_CTL_WR: begin
            spare_n = ctl_spare;
            empty_n = ctl_empty;
            full_n  = ctl_full;
            if (ctl_empty) cnt_n = '0;
         end
         OP_POP: begin
            full_n = 1'b0;
            if (pop_ok) begin
               head_n = head + 1'b1;
               cnt_n  = count - 1'b1;
            end
            if (cnt_n == '0) empty_n = 1'b1;
         end
         OP_PUSH: begin
            empty_n = 1'b0;
            if (push_ok) cnt_n = count + 1'b1;
            if (cnt_n == CNT_FULL) full_n = 1'b1;
         end
         OP_HOLD_RD: full_n  = 1'b0;
         OP_HOLD_WR: empty_n = 1'b0;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_spare <= 1'b0;
         flag_empty <= 1'b1;
         flag_full  <= 1'b0;
         count      <= '0;
         head       <= '0;
      end else begin
         flag_spare <= spare_n;
         flag_empty <= empty_n;
         flag_full  <= full_n;
         count      <= cnt_n;
         head       <= head_n;
      end
   end

endmodule

// File: rtl/itc_cell_waiter.sv
module itc_cell_waiter #(
   parameter int ID_W   = 6,
   parameter int MASK_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              park,
   input  logic [ID_W-1:0]   park_id,
   input  logic              release_all,
   output logic [MASK_W-1:0] parked,
   output logic [MASK_W-1:0] wake_vec
);

   logic [MASK_W-1:0] id_bit;

   always_comb begin
      id_bit = '0;
      id_bit[park_id] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         parked   <= '0;
         wake_vec <= '0;
      end else begin
         wake_vec <= release_all ? parked : '0;
         if (park) begin
            parked <= parked | id_bit;
         end else if (release_all) begin
            parked <= '0;
         end
      end
   end

endmodule

// File: rtl/itc_fifo_cell.sv
module itc_fifo_cell
   import itc_cell_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 64,
   parameter int ID_W   = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic                  req_write,
   input  logic [3:0]            req_view,
   input  logic [ID_W-1:0]       req_id,
   input  logic [DATA_W-1:0]     req_wdata,
   output logic                  rsp_valid,
   output logic                  rsp_stall,
   output logic [DATA_W-1:0]     rsp_rdata,
   output logic [(1<<ID_W)-1:0]  wake_vec
);

   localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W  = $clog2(DEPTH + 1);
   localparam int MASK_W = 1 << ID_W;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 32) begin : g_bad_width
      $error("DATA_W must hold the 32-bit tag word");
   end
   if (CNT_W > TAG_COUNT_W || PTR_W >= (1 << TAG_DEPTH_W)) begin : g_bad_tag
      $error("DEPTH does not fit the tag fields");
   end

   logic             tag_spare, tag_e, tag_f;
   logic [CNT_W-1:0] tag_cnt;
   logic [PTR_W-1:0] tag_head;
   logic             push_ok, pop_ok;
   tag_op_e          op;

   logic              is_queue, is_wait, hold_rd, hold_wr, served_q;
   logic              raw_wr_ok, st_wr_en;
   logic [PTR_W-1:0]  st_wr_slot;
   logic [DATA_W-1:0] head_data, tag_word, rdata_n;
   logic [MASK_W-1:0] blk_mask;

   assign is_queue = (req_view == VIEW_Q_WAIT) || (req_view == VIEW_Q_POLL);
   assign is_wait  = (req_view == VIEW_Q_WAIT);
   assign hold_rd  = req_valid && is_queue && !req_write && is_wait && tag_e;
   assign hold_wr  = req_valid && is_queue && req_write && is_wait && tag_f;
   assign served_q = req_valid && is_queue && !hold_rd && !hold_wr;
   assign raw_wr_ok = req_valid && req_write && (req_view == VIEW_RAW) &&
                      (tag_cnt != '0);

   always_comb begin
      op = OP_IDLE;
      if (req_valid) begin
         if (hold_rd)                                   op = OP_HOLD_RD;
         else if (hold_wr)                              op = OP_HOLD_WR;
         else if (is_queue)                             op = req_write ? OP_PUSH : OP_POP;
         else if (req_view == VIEW_TAG && req_write)    op = OP_CTL_WR;
      end
   end

   itc_cell_tag #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_tag (
      .clk        (clk),
      .rst_n      (rst_n),
      .op         (op),
      .ctl_spare  (req_wdata[TAG_SPARE_BIT]),
      .ctl_empty  (req_wdata[TAG_EMPTY_BIT]),
      .ctl_full   (req_wdata[TAG_FULL_BIT]),
      .flag_spare (tag_spare),
      .flag_empty (tag_e),
      .flag_full  (tag_f),
      .count      (tag_cnt),
      .head       (tag_head),
      .push_ok    (push_ok),
      .pop_ok     (pop_ok)
   );

   // Newest entry sits one slot behind the append slot; index arithmetic wraps.
   assign st_wr_en   = push_ok || raw_wr_ok;
   assign st_wr_slot = tag_head + PTR_W'(tag_cnt) - PTR_W'(raw_wr_ok);

   itc_cell_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (st_wr_en),
      .wr_slot (st_wr_slot),
      .wr_data (req_wdata),
      .rd_slot (tag_head),
      .rd_data (head_data)
   );

   itc_cell_waiter #(.ID_W(ID_W), .MASK_W(MASK_W)) u_wait (
      .clk         (clk),
      .rst_n       (rst_n),
      .park        (hold_rd || hold_wr),
      .park_id     (req_id),
      .release_all (served_q),
      .parked      (blk_mask),
      .wake_vec    (wake_vec)
   );

   always_comb begin
      tag_word = '0;
      tag_word[TAG_DEPTH_LSB +: TAG_DEPTH_W] = TAG_DEPTH_W'(PTR_W);
      tag_word[TAG_COUNT_LSB +: TAG_COUNT_W] = TAG_COUNT_W'(tag_cnt);
      tag_word[TAG_QMODE_BIT] = 1'b1;
      tag_word[TAG_SPARE_BIT] = tag_spare;
      tag_word[TAG_FULL_BIT]  = tag_f;
      tag_word[TAG_EMPTY_BIT] = tag_e;
   end

   always_comb begin
      rdata_n = '0;
      if (!req_write) begin
         case (req_view)
            VIEW_RAW:    rdata_n = head_data;
            VIEW_TAG:    rdata_n = tag_word;
            VIEW_Q_WAIT,
            VIEW_Q_POLL: rdata_n = pop_ok ? head_data : '0;
            default:     rdata_n = '1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_stall <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_stall <= hold_rd || hold_wr;
         rsp_rdata <= req_valid ? rdata_n : '0;
      end
   end

endmodule

// File: rtl/itc_cell_chk.sv
module itc_cell_chk #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 64,
   parameter int ID_W   = 6
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              req_valid,
   input logic                              req_write,
   input logic [3:0]                        req_view,
   input logic [ID_W-1:0]                   req_id,
   input logic [DATA_W-1:0]                 req_wdata,
   input logic                              rsp_valid,
   input logic                              rsp_stall,
   input logic [DATA_W-1:0]                 rsp_rdata,
   input logic [(1<<ID_W)-1:0]              wake_vec,
   input logic [$clog2(DEPTH+1)-1:0]        count,
   input logic                              flag_e,
   input logic                              flag_f,
   input logic [(1<<ID_W)-1:0]              parked
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);                                           // R2
   AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);                                         // R2
   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));                                            // R6
   AST_EMPTY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_view == 4'd1 && req_wdata[0])
      |=> (count == '0) && flag_e);                                       // R4
   AST_FILL_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && (req_view == 4'd3 ||
       (req_view == 4'd2 && !flag_f)) && count == CNT_W'(DEPTH - 1))
      |=> flag_f);                                                        // R6
   AST_WAIT_RD_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_view == 4'd2 && flag_e)
      |=> rsp_stall && (count == $past(count)) && parked[$past(req_id)]); // R7
   AST_WAIT_WR_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_view == 4'd2 && flag_f)
      |=> rsp_stall && (count == $past(count)) && !flag_e);               // R8
   AST_WAKE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (|wake_vec) |-> $past(req_valid) && !rsp_stall &&
      ($past(req_view) == 4'd2 || $past(req_view) == 4'd3));              // R9
   AST_BAD_VIEW_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_view > 4'd3) |=> (&rsp_rdata));     // R11

endmodule

bind itc_fifo_cell itc_cell_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ID_W(ID_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_view  (req_view),
   .req_id    (req_id),
   .req_wdata (req_wdata),
   .rsp_valid (rsp_valid),
   .rsp_stall (rsp_stall),
   .rsp_rdata (rsp_rdata),
   .wake_vec  (wake_vec),
   .count     (tag_cnt),
   .flag_e    (tag_e),
   .flag_f    (tag_f),
   .parked    (blk_mask)
);

// File: tb/itc_fifo_cell_tb_top.sv
module itc_fifo_cell_tb_top;

   localparam int D = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [3:0]  req_view = '0;
   logic [5:0]  req_id = '0;
   logic [63:0] req_wdata = '0;
   logic        rsp_valid, rsp_stall;
   logic [63:0] rsp_rdata, wake_vec;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   itc_fifo_cell dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_view(req_view), .req_id(req_id), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_stall(rsp_stall), .rsp_rdata(rsp_rdata),
      .wake_vec(wake_vec)
   );

   // behavioural reference state
   logic [63:0] ring [D];
   int          hd, cnt;
   bit          m_t, m_e, m_f;
   logic [63:0] m_mask;

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < D; i++) ring[i] = '0;
      hd = 0; cnt = 0; m_t = 0; m_e = 1; m_f = 0; m_mask = '0;
   endtask

   task automatic model_step(input bit wr, input int vw, input int id,
                             input logic [63:0] d, output bit es,
                             output logic [63:0] er, output logic [63:0] ew);
      es = 0; er = '0; ew = '0;
      if (vw == 0) begin
         if (!wr) er = ring[hd];
         else if (cnt > 0) ring[(hd + cnt - 1) % D] = d;
      end else if (vw == 1) begin
         if (!wr) begin
            er = (64'(3) << 28) | (64'(cnt) << 18) | (64'(1) << 17) |
                 (64'(m_t) << 16) | (64'(m_f) << 1) | 64'(m_e);
         end else begin
            m_t = d[16]; m_e = d[0]; m_f = d[1];
            if (m_e) cnt = 0;
         end
      end else if (vw == 2 || vw == 3) begin
         if (!wr) begin
            m_f = 0;
            if (vw == 2 && m_e) begin
               es = 1; m_mask[id] = 1'b1;
            end else begin
               ew = m_mask; m_mask = '0;
               if (cnt > 0) begin
                  er = ring[hd]; hd = (hd + 1) % D; cnt--;
               end
               if (cnt == 0) m_e = 1;
            end
         end else begin
            m_e = 0;
            if (vw == 2 && m_f) begin
               es = 1; m_mask[id] = 1'b1;
            end else begin
               ew = m_mask; m_mask = '0;
               if (cnt < D) begin
                  ring[(hd + cnt) % D] = d; cnt++;
               end
               if (cnt == D) m_f = 1;
            end
         end
      end else if (!wr) begin
         er = '1;
      end
   endtask

   // called on a falling edge; compares on the next falling edge
   task automatic send(input bit wr, input int vw, input int id,
                       input logic [63:0] d, input string req);
      bit es;
      logic [63:0] er, ew;
      req_valid = 1; req_write = wr; req_view = 4'(vw);
      req_id = 6'(id); req_wdata = d;
      model_step(wr, vw, id, d, es, er, ew);
      @(negedge clk);
      req_valid = 0;
      chk("R2", "rsp_valid", 64'(rsp_valid), 64'd1);
      chk(req, "rsp_stall", 64'(rsp_stall), 64'(es));
      chk(req, "rsp_rdata", rsp_rdata, er);
      chk("R9", "wake_vec", wake_vec, ew);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk("R2", "idle rsp_valid", 64'(rsp_valid), 64'd0);
         chk("R9", "idle wake_vec", wake_vec, 64'd0);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
   end

   initial begin
      logic [31:0] lfsr;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset outputs and tag word
      @(negedge clk);
      chk("R1", "rsp_rdata", rsp_rdata, 64'd0);
      chk("R1", "wake_vec", wake_vec, 64'd0);
      send(0, 1, 0, 0, "R1");
      chk("R1", "reset tag literal", 64'h3002_0001, rsp_rdata);
      send(0, 0, 0, 0, "R10");              // raw read at reset -> 0
      send(0, 3, 1, 0, "R5");               // poll read empty -> 0
      // R7: waiting reads park requesters 5 and 9
      send(0, 2, 5, 0, "R7");
      send(0, 2, 9, 0, "R7");
      send(0, 1, 0, 0, "R7");               // count still 0
      idle(2);
      // R6/R9: first push wakes both
      send(1, 3, 2, 64'hA1, "R6");
      for (int i = 1; i < D; i++) send(1, 2, 2, 64'hA0 + 64'(i) + 64'h100, "R6");
      send(0, 1, 0, 0, "R6");               // count 8, full set
      // R8: waiting write on full stalls, then poll write dropped and wakes
      send(1, 2, 3, 64'hDEAD, "R8");
      send(0, 1, 0, 0, "R8");
      send(1, 3, 4, 64'hBEEF, "R6");
      // R10: raw read head, raw write newest
      send(0, 0, 0, 0, "R10");
      send(0, 0, 0, 0, "R10");
      send(1, 0, 0, 64'h5555, "R10");
      // R5: drain all entries
      for (int i = 0; i < D; i++) send(0, 3, 0, 0, "R5");
      send(0, 3, 0, 0, "R5");               // empty -> 0
      send(0, 1, 0, 0, "R5");
      // R10: raw write while empty ignored
      send(1, 0, 0, 64'h7777, "R10");
      send(0, 0, 0, 0, "R10");
      // R4: tag writes
      send(1, 1, 0, 64'h0001_0002, "R4");
      send(0, 1, 0, 0, "R4");
      send(1, 3, 0, 64'h11, "R4");
      send(1, 3, 0, 64'h22, "R4");
      send(1, 1, 0, 64'h0000_0001, "R4");
      send(0, 1, 0, 0, "R4");
      // R11: unsupported views
      send(0, 7, 0, 0, "R11");
      send(0, 15, 0, 0, "R11");
      send(1, 9, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R11");
      send(0, 1, 0, 0, "R11");
      send(0, 0, 0, 0, "R11");
      // R3: mixed traffic including wrap-around
      lfsr = 32'h1D2C_3B4A;
      for (int k = 0; k < 400; k++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         send(lfsr[2], int'(lfsr[1:0]), int'(lfsr[8:3]),
              {lfsr, ~lfsr} & ((lfsr[12:9] == 0) ? 64'hFFFF_FFFF_FFFE_FFFF
                                                  : 64'hFFFF_FFFF_FFFF_FFFC), "R3");
         if (lfsr[15:13] == 0) idle(1);
      end
      send(0, 1, 0, 0, "R3");
      idle(2);
      summary();
   end

endmodule